// File: doc/BRIEF.md
# Console Terminal I/O Controller

This block sits on a 12-bit programmed-I/O bus and serves a console terminal through two independent channels. The receive channel holds the last character that arrived from the terminal and raises a ready flag. The transmit channel hands a character from the accumulator to a serializer and raises its own ready flag once the serializer reports that the character has gone out. Each channel answers one device code. The CPU presents a decoded I/O-transfer instruction: a strobe, a 6-bit device code and a 3-bit operation field.

Each bit of the operation field starts its own micro-action, so one instruction can combine several actions. The responses to an instruction are combinational and valid in the same cycle as the instruction strobe. They are a skip request, an accumulator-clear request and a word to OR into the accumulator, which the CPU applies clear-first. Flag changes take effect at the next clock edge. The interrupt request is the OR of both flags.

Neither stream has back-pressure. A received character is always taken and overwrites the previous one. A transmit strobe lasts exactly one cycle, and software paces output by testing the printer flag. The two completion inputs are single-cycle pulses.

Top module: `conio_ctrl`

## Requirements
- R1: After reset both flags are clear, `irq` is 0, and with no instruction strobe `skip_req`, `acc_clr`, `acc_or` and `tx_valid` are 0.
- R2: A cycle with `rx_valid` high stores `rx_data` and sets the keyboard flag from the next cycle. If a second character arrives while the flag is set, the stored byte is replaced and the flag stays set.
- R3: The keyboard answers device code 3. Op bit 0 (value 1) drives `skip_req` high in that cycle when the keyboard flag is set, using the flag value from before any clear in the same instruction.
- R4: Keyboard op bit 1 (value 2) drives `acc_clr` high in that cycle and clears the keyboard flag from the next cycle.
- R5: Keyboard op bit 2 (value 4) drives the stored byte on `acc_or[7:0]` with `acc_or[11:8]` zero. Op 6 gives `acc_clr` and the byte together, so the CPU ends up with only the new byte. Op 0 does nothing.
- R6: The printer answers device code 4. Op bit 0 (value 1) drives `skip_req` high when the printer flag is set, using the flag value from before any clear.
- R7: Printer op bit 1 (value 2) clears the printer flag from the next cycle and never requests an accumulator clear.
- R8: Printer op bit 2 (value 4) pulses `tx_valid` for that cycle with `tx_data` equal to `acc_in[7:0]`. Otherwise `tx_data` is 0.
- R9: Only a `tx_done` pulse sets the printer flag, from the next cycle. Printing alone leaves the flag clear.
- R10: A cycle with `mclr` high clears both flags from the next cycle, whatever else happens in that cycle.
- R11: `irq` is high exactly when at least one flag is set.
- R12: With `iot_valid` low, or with a device code other than 3 or 4, an instruction produces no response and changes no flag.
- R13: A character arrival in the same cycle as a keyboard clear leaves the flag set and stores the new byte. A `tx_done` in the same cycle as a printer clear leaves the printer flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Master clear of both flags |
| iot_valid | input | 1 | Decoded I/O-transfer instruction strobe |
| iot_dev | input | 6 | Device code of the instruction |
| iot_op | input | 3 | Operation bits of the instruction |
| acc_in | input | 12 | Current accumulator |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| tx_done | input | 1 | Transmitter finished a character |
| skip_req | output | 1 | Request to skip the next instruction |
| acc_clr | output | 1 | Request to clear the accumulator |
| acc_or | output | 12 | Word to OR into the accumulator |
| tx_valid | output | 1 | Transmit strobe |
| tx_data | output | 8 | Transmit character |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle: an instruction that clears a flag together with the event that sets that flag, and a skip test together with a clear of the same flag. The bench provokes the first pair by raising `rx_valid` or `tx_done` in the strobe cycle of a clear instruction. It judges the result by reading the flag back with a later skip test and by reading the stored byte. For the second pair it sweeps every device code and op value against every starting combination of flags. It predicts the skip from the flag value before the clear and the flag afterwards from the clear bit.

// File: rtl/conio_pkg.sv
package conio_pkg;
  // Positions of the micro-action bits in the operation field
  localparam int OP_W      = 3;
  localparam int OP_TEST   = 0;
  localparam int OP_CLEAR  = 1;
  localparam int OP_XFER   = 2;

  typedef struct packed {
    logic skip;
    logic clr;
  } chan_resp_t;
endpackage

// File: rtl/conio_kbd_chan.sv
module conio_kbd_chan
  import conio_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              sel,
  input  logic [OP_W-1:0]   op,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output chan_resp_t        resp,
  output logic [WORD_W-1:0] or_data,
  output logic              flag
);
  localparam int PAD_W = WORD_W - BYTE_W;

  logic [BYTE_W-1:0] rx_byte_q;
  logic              flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      rx_byte_q <= '0;
    end else begin
      if (mclr)
        flag_q <= 1'b0;
      else if (rx_valid)
        flag_q <= 1'b1;               // arrival wins over a same-cycle clear
      else if (sel && op[OP_CLEAR])
        flag_q <= 1'b0;
      if (rx_valid)
        rx_byte_q <= rx_data;
    end
  end

  always_comb begin
    resp.skip = sel && op[OP_TEST] && flag_q;   // pre-clear flag value
    resp.clr  = sel && op[OP_CLEAR];
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign or_data = (sel && op[OP_XFER]) ? {{PAD_W{1'b0}}, rx_byte_q} : '0;
    end else begin : g_nopad
      assign or_data = (sel && op[OP_XFER]) ? rx_byte_q[WORD_W-1:0] : '0;
    end
  endgenerate

  assign flag = flag_q;
endmodule

// File: rtl/conio_prt_chan.sv
module conio_prt_chan
  import conio_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              sel,
  input  logic [OP_W-1:0]   op,
  input  logic [BYTE_W-1:0] acc_lo,
  input  logic              tx_done,
  output chan_resp_t        resp,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (mclr)
      flag_q <= 1'b0;
    else if (tx_done)
      flag_q <= 1'b1;                 // completion wins over a same-cycle clear
    else if (sel && op[OP_CLEAR])
      flag_q <= 1'b0;
  end

  always_comb begin
    resp.skip = sel && op[OP_TEST] && flag_q;
    resp.clr  = 1'b0;
    tx_valid  = sel && op[OP_XFER];
    tx_data   = tx_valid ? acc_lo : '0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/conio_ctrl.sv
module conio_ctrl
  import conio_pkg::*;
#(
  parameter int          WORD_W  = 12,
  parameter int          BYTE_W  = 8,
  parameter int          DEV_W   = 6,
  parameter logic [5:0]  DEV_KBD = 6'd3,
  parameter logic [5:0]  DEV_PRT = 6'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              iot_valid,
  input  logic [DEV_W-1:0]  iot_dev,
  input  logic [OP_W-1:0]   iot_op,
  input  logic [WORD_W-1:0] acc_in,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              tx_done,
  output logic              skip_req,
  output logic              acc_clr,
  output logic [WORD_W-1:0] acc_or,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  logic       kbd_sel, prt_sel;
  logic       kbd_flag, prt_flag;
  chan_resp_t kbd_resp, prt_resp;
  logic [WORD_W-1:0] kbd_or;
  logic       unused_acc_hi;

  assign kbd_sel = iot_valid && (iot_dev == DEV_KBD[DEV_W-1:0]);
  assign prt_sel = iot_valid && (iot_dev == DEV_PRT[DEV_W-1:0]);
  assign unused_acc_hi = ^acc_in[WORD_W-1:BYTE_W];

  conio_kbd_chan #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_kbd (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .sel(kbd_sel), .op(iot_op),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .resp(kbd_resp), .or_data(kbd_or), .flag(kbd_flag)
  );

  conio_prt_chan #(.BYTE_W(BYTE_W)) u_prt (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .sel(prt_sel), .op(iot_op),
    .acc_lo(acc_in[BYTE_W-1:0]), .tx_done(tx_done),
    .resp(prt_resp), .tx_valid(tx_valid), .tx_data(tx_data), .flag(prt_flag)
  );

  assign skip_req = kbd_resp.skip | prt_resp.skip;
  assign acc_clr  = kbd_resp.clr  | prt_resp.clr;
  assign acc_or   = kbd_or;
  assign irq      = kbd_flag | prt_flag;
endmodule

// File: rtl/conio_ctrl_chk.sv
module conio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mclr,
  input logic        iot_valid,
  input logic [2:0]  iot_op,
  input logic        rx_valid,
  input logic        tx_done,
  input logic        skip_req,
  input logic        acc_clr,
  input logic [11:0] acc_or,
  input logic        tx_valid,
  input logic        irq,
  input logic        kbd_sel,
  input logic        kbd_flag,
  input logic        prt_flag
);
  a_r2_arrival_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !mclr) |=> kbd_flag);

  a_r4_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_sel && iot_op[1] && !rx_valid && !mclr) |=> !kbd_flag);

  a_r9_only_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prt_flag) |-> $past(tx_done));

  a_r10_mclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> !irq);

  a_r11_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (kbd_flag || prt_flag));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !iot_valid |-> (!skip_req && !acc_clr && acc_or == 12'd0 && !tx_valid));
endmodule

bind conio_ctrl conio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mclr(mclr), .iot_valid(iot_valid),
  .iot_op(iot_op), .rx_valid(rx_valid), .tx_done(tx_done),
  .skip_req(skip_req), .acc_clr(acc_clr), .acc_or(acc_or),
  .tx_valid(tx_valid), .irq(irq), .kbd_sel(kbd_sel),
  .kbd_flag(kbd_flag), .prt_flag(prt_flag)
);

// File: tb/conio_ctrl_tb_top.sv
module conio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mclr = 1'b0;
  logic        iot_valid = 1'b0;
  logic [5:0]  iot_dev = '0;
  logic [2:0]  iot_op = '0;
  logic [11:0] acc_in = '0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_done = 1'b0;
  logic        skip_req, acc_clr, tx_valid, irq;
  logic [11:0] acc_or;
  logic [7:0]  tx_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  conio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .iot_valid(iot_valid),
    .iot_dev(iot_dev), .iot_op(iot_op), .acc_in(acc_in),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_done(tx_done),
    .skip_req(skip_req), .acc_clr(acc_clr), .acc_or(acc_or),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic pulse_rx(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b; nxt(); rx_valid = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done = 1'b1; nxt(); tx_done = 1'b0;
  endtask

  task automatic pulse_mclr();
    mclr = 1'b1; nxt(); mclr = 1'b0;
  endtask

  // Read a flag through a skip test on the given device
  task automatic query(input logic [5:0] dev, output bit f);
    iot_valid = 1'b1; iot_dev = dev; iot_op = 3'd1; #1;
    f = skip_req;
    nxt(); iot_valid = 1'b0; iot_op = 3'd0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    bit f;
    logic [7:0] last_b;
    last_b = 8'd0;
    nxt(); nxt();
    rst_n = 1'b1;
    nxt(); #1;
    // R1 reset state
    chk(int'(irq), 0, "R1 irq after reset");
    chk(int'(skip_req), 0, "R1 skip idle");
    chk(int'(acc_clr), 0, "R1 clr idle");
    chk(int'(acc_or), 0, "R1 or idle");
    chk(int'(tx_valid), 0, "R1 tx idle");
    query(6'd3, f); chk(int'(f), 0, "R1 kbd flag clear");
    query(6'd4, f); chk(int'(f), 0, "R1 prt flag clear");

    // R9 printing alone does not set the flag
    iot_valid = 1'b1; iot_dev = 6'd4; iot_op = 3'd4; acc_in = 12'hA5C; #1;
    chk(int'(tx_valid), 1, "R8 tx strobe");
    chk(int'(tx_data), 8'h5C, "R8 tx byte");
    nxt(); iot_valid = 1'b0; nxt(); nxt();
    query(6'd4, f); chk(int'(f), 0, "R9 print without done");
    pulse_done(); #1;
    chk(int'(irq), 1, "R9 done sets flag, R11 irq");

    // R2 overwrite while flag set
    pulse_mclr();
    pulse_rx(8'h11); pulse_rx(8'h22); last_b = 8'h22;
    iot_valid = 1'b1; iot_dev = 6'd3; iot_op = 3'd4; #1;
    chk(int'(acc_or), 8'h22, "R2 overwritten byte");
    nxt(); iot_valid = 1'b0;
    query(6'd3, f); chk(int'(f), 1, "R2 flag stays set");

    // R13 arrival in the same cycle as clear+read
    iot_valid = 1'b1; iot_dev = 6'd3; iot_op = 3'd6; rx_valid = 1'b1; rx_data = 8'h3C; #1;
    chk(int'(acc_clr), 1, "R13 clr same cycle");
    chk(int'(acc_or), 8'h22, "R13 old byte read");
    nxt(); iot_valid = 1'b0; rx_valid = 1'b0; last_b = 8'h3C;
    query(6'd3, f); chk(int'(f), 1, "R13 arrival wins");
    iot_valid = 1'b1; iot_dev = 6'd3; iot_op = 3'd4; #1;
    chk(int'(acc_or), 8'h3C, "R13 new byte stored");
    nxt(); iot_valid = 1'b0;

    // R13 done in the same cycle as printer clear
    pulse_mclr();
    iot_valid = 1'b1; iot_dev = 6'd4; iot_op = 3'd2; tx_done = 1'b1;
    nxt(); iot_valid = 1'b0; tx_done = 1'b0;
    query(6'd4, f); chk(int'(f), 1, "R13 done wins");

    // R10 master clear with a same-cycle arrival
    pulse_rx(8'h3C);
    mclr = 1'b1; rx_valid = 1'b1; rx_data = 8'h3C; nxt(); mclr = 1'b0; rx_valid = 1'b0; #1;
    chk(int'(irq), 0, "R10 mclr clears both");

    // R12 strobe low: no response, no flag change
    pulse_rx(8'h3C); pulse_done();
    iot_valid = 1'b0; iot_dev = 6'd3; iot_op = 3'd7; #1;
    chk(int'(skip_req | acc_clr | tx_valid), 0, "R12 strobe low quiet");
    chk(int'(acc_or), 0, "R12 strobe low or");
    nxt(); iot_dev = 6'd4; nxt();
    query(6'd3, f); chk(int'(f), 1, "R12 kbd flag kept");
    query(6'd4, f); chk(int'(f), 1, "R12 prt flag kept");

    // Sweep: every device, op and starting flag pair (R3..R8, R11, R12)
    for (int it = 0; it < 64 * 8 * 4; it++) begin
      logic [5:0] dev;
      logic [2:0] op;
      bit ks, ps, isk, isp, ek, ep;
      logic [7:0] b;
      logic [11:0] acc;
      dev = 6'(it >> 5); op = 3'(it >> 2); ks = it[0]; ps = it[1];
      b = 8'((it * 37 + 5) & 255); acc = 12'((it * 13 + 7) & 12'hfff);
      pulse_mclr();
      if (ks) begin pulse_rx(b); last_b = b; end
      if (ps) pulse_done();
      isk = (dev == 6'd3); isp = (dev == 6'd4);
      iot_valid = 1'b1; iot_dev = dev; iot_op = op; acc_in = acc; #1;
      chk(int'(skip_req), int'((isk & op[0] & ks) | (isp & op[0] & ps)), "R3 R6 skip");
      chk(int'(acc_clr), int'(isk & op[1]), "R4 R7 clr");
      chk(int'(acc_or), (isk & op[2]) ? int'(last_b) : 0, "R5 or data");
      chk(int'(tx_valid), int'(isp & op[2]), "R8 tx strobe");
      chk(int'(tx_data), (isp & op[2]) ? int'(acc[7:0]) : 0, "R8 tx data");
      nxt(); iot_valid = 1'b0; iot_op = 3'd0; #1;
      ek = ks & !(isk & op[1]); ep = ps & !(isp & op[1]);
      chk(int'(irq), int'(ek | ep), "R11 irq after op, R12 other devices");
      query(6'd3, f); chk(int'(f), int'(ek), "R4 kbd flag after op");
      query(6'd4, f); chk(int'(f), int'(ep), "R7 prt flag after op");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule